// File: doc/BRIEF.md
# Segment Selector Translation Unit

This block turns a logical address into a 32-bit linear address. A logical address is a 16-bit selector plus a 32-bit offset. The unit decodes the selector and picks either the global or the local descriptor table. It reads the 8-byte descriptor from memory as two word reads over a request/acknowledge port. From that descriptor it unpacks the segment base, the limit, the granularity flag and the present flag.

It then compares the offset with the effective limit and adds the base. A null selector, a descriptor that is not present, or an offset past the limit raises a fault in place of producing an address. The requested privilege level taken from the selector is reported with every result.

One translation is in flight at a time. The caller pulses a request and waits for the one-cycle done pulse.

Top module: `seg_xlate`

## Requirements
- R1: Selector bits [1:0] are the requested privilege level, bit 2 picks the table (0 = global, 1 = local), and bits [15:3] are the index. The descriptor address is the chosen table base plus index × 8.
- R2: The descriptor is read as two 32-bit words: bits [31:0] at the descriptor address, then bits [63:32] at that address + 4. Each read holds mem_req_o and a stable mem_addr_o until mem_ack_i is seen, and mem_rdata_i is taken in the cycle of the acknowledge.
- R3: The segment base is descriptor bits {[63:56], [39:16]}.
- R4: The raw 20-bit limit is {bits [51:48], bits [15:0]}. When bit 55 is 1, the effective limit is the raw limit shifted left by 12 with ones in the low 12 bits; otherwise it is the raw limit zero-extended.
- R5: An offset equal to the effective limit translates; an offset greater than it faults.
- R6: A descriptor whose bit 47 is 0 faults.
- R7: A selector with bit 2 = 0 and index 0 faults with no memory read, and done_o follows one cycle after acceptance. Index 0 of the local table is fetched and translated normally.
- R8: done_o pulses for one cycle, one cycle after the acknowledge of the second read. Without a fault, lin_addr_o is (base + offset) mod 2^32; with a fault, lin_addr_o is 0.
- R9: rpl_o shows selector bits [1:0] of the request that finished, valid with done_o.
- R10: A request raised while a translation is in flight is ignored. It makes no extra done_o pulse and does not change the result of the translation in flight.
- R11: After reset, done_o, fault_o, mem_req_o and lin_addr_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request, taken only while idle |
| selector_i | input | 16 | Segment selector |
| offset_i | input | 32 | Offset within the segment |
| gdt_base_i | input | 32 | Byte address of the global descriptor table |
| ldt_base_i | input | 32 | Byte address of the local descriptor table |
| mem_req_o | output | 1 | Descriptor word read request |
| mem_addr_o | output | 32 | Byte address of the word being read |
| mem_ack_i | input | 1 | Read acknowledge; data valid in the same cycle |
| mem_rdata_i | input | 32 | Read data |
| done_o | output | 1 | One-cycle result strobe |
| lin_addr_o | output | 32 | Linear address (0 on fault) |
| fault_o | output | 1 | Translation fault, valid with done_o |
| rpl_o | output | 2 | Requested privilege level of the finished request |

## Verification
A wrong fetch state shows up on the memory port within a cycle or two. The signs are a second read at the wrong address, a read issued for a null selector, or a read count other than two per translation. A wrong base or limit unpack shows up only at done_o, as a wrong linear address or a wrong fault. For that reason the descriptors place distinct values in every base and limit fragment, and offsets are chosen exactly at the effective limit and one past it. A stuck busy or idle state shows as a missing or extra done pulse within the latency of one fetch.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int ADDR_W = 32;
  localparam int DESC_W = 64;

  typedef enum logic [1:0] {ST_IDLE, ST_LO, ST_HI} fetch_st_e;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;
    logic              present;
  } seg_desc_t;
endpackage

// File: rtl/sel_decode.sv
module sel_decode
  import seg_pkg::*;
#(
  parameter int SEL_W = 16
) (
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [ADDR_W-1:0] gdt_base_i,
  input  logic [ADDR_W-1:0] ldt_base_i,
  output logic [ADDR_W-1:0] desc_addr_o,
  output logic [1:0]        rpl_o,
  output logic              null_o
);
  localparam int IDX_W = SEL_W - 3;

  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] tbl_base;

  assign idx         = sel_i[SEL_W-1:3];
  assign rpl_o       = sel_i[1:0];
  assign tbl_base    = sel_i[2] ? ldt_base_i : gdt_base_i;
  assign desc_addr_o = tbl_base + ADDR_W'({idx, 3'b000});
  assign null_o      = !sel_i[2] && (idx == '0);
endmodule

// File: rtl/desc_unpack.sv
module desc_unpack
  import seg_pkg::*;
#(
  parameter int GRAN_SHIFT = 12
) (
  input  logic [DESC_W-1:0] raw_i,
  output seg_desc_t         desc_o
);
  localparam int LIM_W = 20;

  logic [LIM_W-1:0] lim_raw;
  logic             gran;

  assign lim_raw = {raw_i[51:48], raw_i[15:0]};
  assign gran    = raw_i[55];

  assign desc_o.base    = {raw_i[63:56], raw_i[39:16]};
  assign desc_o.limit   = gran ? ADDR_W'({lim_raw, {GRAN_SHIFT{1'b1}}})
                               : ADDR_W'(lim_raw);
  assign desc_o.present = raw_i[47];
endmodule

// File: rtl/seg_fetch.sv
module seg_fetch
  import seg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              null_i,
  input  logic [ADDR_W-1:0] desc_addr_i,
  output logic              idle_o,
  output logic              null_done_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              desc_vld_o,
  output logic [DESC_W-1:0] desc_raw_o
);
  localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(4);

  fetch_st_e         st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       lo_q;

  assign idle_o      = (st_q == ST_IDLE);
  assign null_done_o = idle_o && start_i && null_i;
  assign mem_req_o   = (st_q == ST_LO) || (st_q == ST_HI);
  assign mem_addr_o  = (st_q == ST_HI) ? addr_q + WORD_BYTES : addr_q;
  assign desc_vld_o  = (st_q == ST_HI) && mem_ack_i;
  assign desc_raw_o  = {mem_rdata_i, lo_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      lo_q   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i && !null_i) begin
          addr_q <= desc_addr_i;
          st_q   <= ST_LO;
        end
        ST_LO: if (mem_ack_i) begin
          lo_q <= mem_rdata_i;
          st_q <= ST_HI;
        end
        ST_HI: if (mem_ack_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R2
  hi_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i && st_q == ST_LO) |=>
      (mem_req_o && mem_addr_o == $past(mem_addr_o) + WORD_BYTES));

  // R7
  null_noread_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && null_i && idle_o) |=> !mem_req_o);
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_pkg::*;
#(
  parameter int SEL_W      = 16,
  parameter int GRAN_SHIFT = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [SEL_W-1:0]  selector_i,
  input  logic [ADDR_W-1:0] offset_i,
  input  logic [ADDR_W-1:0] gdt_base_i,
  input  logic [ADDR_W-1:0] ldt_base_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              done_o,
  output logic [ADDR_W-1:0] lin_addr_o,
  output logic              fault_o,
  output logic [1:0]        rpl_o
);
  logic [ADDR_W-1:0] desc_addr;
  logic [1:0]        sel_rpl;
  logic              sel_null;
  logic              idle, null_done, desc_vld, accept;
  logic [DESC_W-1:0] desc_raw;
  seg_desc_t         desc;
  logic [ADDR_W-1:0] off_q;
  logic [1:0]        rpl_q;
  logic              seg_fault;

  sel_decode #(.SEL_W(SEL_W)) u_dec (
    .sel_i       (selector_i),
    .gdt_base_i  (gdt_base_i),
    .ldt_base_i  (ldt_base_i),
    .desc_addr_o (desc_addr),
    .rpl_o       (sel_rpl),
    .null_o      (sel_null)
  );

  seg_fetch u_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (req_valid_i),
    .null_i      (sel_null),
    .desc_addr_i (desc_addr),
    .idle_o      (idle),
    .null_done_o (null_done),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .desc_vld_o  (desc_vld),
    .desc_raw_o  (desc_raw)
  );

  desc_unpack #(.GRAN_SHIFT(GRAN_SHIFT)) u_unpack (
    .raw_i  (desc_raw),
    .desc_o (desc)
  );

  assign accept    = req_valid_i && idle;
  assign seg_fault = !desc.present || (off_q > desc.limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q      <= '0;
      rpl_q      <= '0;
      done_o     <= 1'b0;
      fault_o    <= 1'b0;
      lin_addr_o <= '0;
      rpl_o      <= '0;
    end else begin
      if (accept) begin
        off_q <= offset_i;
        rpl_q <= sel_rpl;
      end
      if (desc_vld) begin
        done_o     <= 1'b1;
        fault_o    <= seg_fault;
        lin_addr_o <= seg_fault ? '0 : desc.base + off_q;
        rpl_o      <= rpl_q;
      end else if (null_done) begin
        done_o     <= 1'b1;
        fault_o    <= 1'b1;
        lin_addr_o <= '0;
        rpl_o      <= sel_rpl;
      end else begin
        done_o <= 1'b0;
      end
    end
  end

  // R7
  null_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && sel_null) |=> (done_o && fault_o));

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !(accept && sel_null)) |=> !done_o);

  // R8
  req_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !done_o);
endmodule

// File: tb/sim_seg_xlate.sv
module sim_seg_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] selector = '0;
  logic [31:0] offset = '0;
  logic [31:0] gdt_base = 32'h100;
  logic [31:0] ldt_base = 32'h300;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done;
  logic [31:0] lin_addr;
  logic        fault;
  logic [1:0]  rpl;

  always #2.5 clk = ~clk;

  seg_xlate u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid),
    .selector_i(selector), .offset_i(offset),
    .gdt_base_i(gdt_base), .ldt_base_i(ldt_base),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .done_o(done), .lin_addr_o(lin_addr), .fault_o(fault), .rpl_o(rpl)
  );

  typedef struct packed {
    logic [31:0] lin;
    logic        flt;
    logic [1:0]  rpl;
    logic [31:0] reads;
    logic [31:0] addr;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0, done_cnt = 0, latency = 0;
  int rd_n = 0;
  logic [31:0] rd_a0, rd_a1;
  bit finished = 0;

  logic [31:0] mem [256];
  logic [31:0] sh_base [2][8];
  logic [19:0] sh_lim  [2][8];
  logic        sh_g    [2][8];
  logic        sh_p    [2][8];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R3 R4 R6: descriptor layout written by the bench
  task automatic set_desc(input int t, input int i, input logic [31:0] b,
                          input logic [19:0] l, input logic g, input logic p);
    logic [63:0] d;
    int w;
    sh_base[t][i] = b; sh_lim[t][i] = l; sh_g[t][i] = g; sh_p[t][i] = p;
    d = '0;
    d[15:0]  = l[15:0];
    d[39:16] = b[23:0];
    d[46:40] = 7'h13;
    d[47]    = p;
    d[51:48] = l[19:16];
    d[54]    = 1'b1;
    d[55]    = g;
    d[63:56] = b[31:24];
    w = ((t != 0 ? 32'h300 : 32'h100) + i * 8) >> 2;
    mem[w]   = d[31:0];
    mem[w+1] = d[63:32];
  endtask

  function automatic exp_t model(input logic [15:0] s, input logic [31:0] off);
    exp_t e;
    int t, i;
    logic [31:0] eff;
    t = int'(s[2]);
    i = int'(s[15:3]);
    e.rpl = s[1:0];
    if (!s[2] && i == 0) begin
      e.flt = 1'b1; e.lin = '0; e.reads = 0; e.addr = '0;
    end else begin
      eff = sh_g[t][i] ? {sh_lim[t][i], 12'hfff} : {12'h0, sh_lim[t][i]};
      e.flt = !sh_p[t][i] || (off > eff);
      e.lin = e.flt ? '0 : sh_base[t][i] + off;
      e.reads = 2;
      e.addr = (s[2] ? 32'h300 : 32'h100) + 32'(i * 8);
    end
    return e;
  endfunction

  // memory responder
  initial begin
    int wait_n = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (wait_n >= latency) begin
          mem_ack = 1'b1;
          mem_rdata = mem[mem_addr[9:2]];
          if (rd_n == 0) rd_a0 = mem_addr; else rd_a1 = mem_addr;
          rd_n++;
          wait_n = 0;
        end else wait_n++;
      end
    end
  end

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        done_cnt++;
        if (q.size() == 0) begin
          chk("R10 unexpected done", 32'(done), 32'h0);
        end else begin
          e = q.pop_front();
          chk("R8 lin_addr", lin_addr, e.lin);
          chk("R5/R6 fault", 32'(fault), 32'(e.flt));
          chk("R9 rpl", 32'(rpl), 32'(e.rpl));
          chk("R2/R7 read count", rd_n, e.reads);
          if (e.reads == 2) begin
            chk("R1 desc addr", rd_a0, e.addr);
            chk("R2 hi addr", rd_a1, e.addr + 4);
          end
        end
      end
    end
  end

  task automatic issue(input logic [15:0] s, input logic [31:0] off);
    int start;
    @(negedge clk);
    rd_n = 0;
    q.push_back(model(s, off));
    start = done_cnt;
    selector = s; offset = off; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (done_cnt == start) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int start;
    for (int k = 0; k < 256; k++) mem[k] = '0;
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < 8; i++) set_desc(t, i, '0, '0, 1'b0, 1'b0);
    set_desc(0, 2, 32'h0, 20'hfffff, 1'b1, 1'b1);
    set_desc(0, 4, 32'h0, 20'hfffff, 1'b1, 1'b1);
    set_desc(0, 5, 32'h0, 20'hfffff, 1'b1, 1'b1);
    set_desc(0, 6, 32'h12345678, 20'h00fff, 1'b0, 1'b1);
    set_desc(0, 7, 32'hfffff000, 20'h00003, 1'b1, 1'b1);
    set_desc(1, 0, 32'h00001000, 20'h00010, 1'b0, 1'b1);
    set_desc(1, 1, 32'h80000000, 20'h00000, 1'b1, 1'b1);
    set_desc(1, 2, 32'h0badf00d, 20'hfffff, 1'b1, 1'b0);

    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 done", 32'(done), 0);
    chk("R11 fault", 32'(fault), 0);
    chk("R11 mem_req", 32'(mem_req), 0);
    chk("R11 lin", lin_addr, 0);
    rst_n = 1'b1;

    for (int lat = 0; lat < 4; lat += 3) begin
      latency = lat;
      issue(16'h0023, 32'hdeadbeef);   // R1 R8 flat user code
      issue(16'h002b, 32'h00000000);   // R9 rpl 3
      issue(16'h0010, 32'hffffffff);   // R4 granular top of 4 GB
      issue(16'h0030, 32'h00000fff);   // R3 R5 at limit
      issue(16'h0030, 32'h00001000);   // R5 one past limit
      issue(16'h003a, 32'h00003fff);   // R8 wrap, R4 scaled limit
      issue(16'h003a, 32'h00004000);   // R5
      issue(16'h0008, 32'h00000000);   // R6 absent
      issue(16'h0003, 32'h00000010);   // R7 null
      issue(16'h0000, 32'h00000000);   // R7 null
      issue(16'h0004, 32'h00000010);   // R7 local index 0 is valid
      issue(16'h0004, 32'h00000011);   // R5
      issue(16'h000f, 32'h00000fff);   // R1 local table, R4
      issue(16'h0017, 32'h00000000);   // R6 absent local
    end

    // R10: second request while busy is ignored
    latency = 3;
    @(negedge clk);
    rd_n = 0;
    start = done_cnt;
    q.push_back(model(16'h0030, 32'h10));
    selector = 16'h0030; offset = 32'h10; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    selector = 16'h0023; offset = 32'h55; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (30) @(negedge clk);
    chk("R10 single done", done_cnt - start, 1);
    chk("R10 queue drained", q.size(), 0);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule